// File: doc/BRIEF.md
# Saturating Vector Narrowing Unit

This block turns a 128-bit vector of wide integer elements into elements of half the width. Each element is clamped to the range of the narrower type. The signedness of the source elements and the signedness of the result elements are chosen independently, so four clamp variants are available. A destination size code selects a result element width of 8, 16 or 32 bits, and each source element is twice that width.

The narrowed lanes always fill 64 bits. Three placement options are available:
- In the lower-half form, the lanes go to the bottom half of the destination and the top half is cleared.
- In the upper-half form, the lanes go to the top half and the bottom half of the current destination is kept.
- In scalar mode, only element 0 is narrowed and every other destination bit is cleared.

Whenever any produced lane had to be clamped, a sticky saturation bit in a 32-bit status word is set. The block is used one operation at a time. The caller presents the operands with a strobe, and the result and status appear together after the next clock edge.

Top module: `sat_narrow_unit`

## Requirements
- R1: Size code 0, 1 and 2 select result widths of 8, 16 and 32 bits, with 8, 4 and 2 lanes. Source element i sits at bits [i*2W +: 2W] of the source vector, and result lane i is written to bits [i*W +: W] of the chosen 64-bit half.
- R2: Signed source with signed result clamps to the range -2^(W-1) to 2^(W-1)-1.
- R3: Signed source with unsigned result turns any negative value into 0 and clamps values above 2^W-1 to 2^W-1.
- R4: Unsigned source with signed result only ever clamps upward, to 2^(W-1)-1.
- R5: Unsigned source with unsigned result only ever clamps upward, to 2^W-1.
- R6: A source value that fits the result type passes through unchanged. This includes negative values when both sides are signed.
- R7: With upper_half low and scalar_mode low, dst_out[127:64] becomes 0 and the lanes occupy dst_out[63:0].
- R8: With upper_half high and scalar_mode low, the lanes occupy dst_out[127:64] and dst_out[63:0] takes dst_cur[63:0].
- R9: With scalar_mode high, only lane 0 is produced at dst_out[W-1:0], all other bits are 0, and upper_half is ignored. Only a clamp of lane 0 sets the flag.
- R10: Bit 27 of status_word is set when any produced lane clamps. It stays set until reset, and all other status bits read 0.
- R11: An operation with size code 3 raises size_err for one cycle and leaves dst_out and status_word unchanged.
- R12: Results are registered. dst_out and status_word change on the clock edge that samples op_valid high, and hold while op_valid is low. Reset clears dst_out, status_word and size_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one operation per cycle it is high |
| src_vec | input | 128 | Wide source elements |
| dst_cur | input | 128 | Current destination contents, used for the upper-half form |
| size_code | input | 2 | Result element size: 0=8b, 1=16b, 2=32b, 3=illegal |
| src_signed | input | 1 | Source elements are two's complement |
| dst_signed | input | 1 | Result elements are two's complement |
| scalar_mode | input | 1 | Narrow element 0 only |
| upper_half | input | 1 | Place lanes in the top 64 bits and keep the bottom 64 bits |
| dst_out | output | 128 | Registered destination result |
| status_word | output | 32 | Sticky status, bit 27 is the saturation flag |
| size_err | output | 1 | One-cycle pulse after an operation with size code 3 |

## Verification
A wrong clamp bound or a swapped signedness path shows up as a wrong lane value in dst_out, on the edge right after the operation. Because of this, the vectors place both in-range and out-of-range elements in every lane position of every size.

A lane mapped to the wrong bit positions corrupts neighbouring lanes at once. A lost or wrongly set flag stays visible in status_word for every later operation, since the bit is sticky.

A register that updates on an illegal size or while idle changes dst_out one edge after the offending cycle. The checks therefore compare dst_out against the last legal result.

// File: rtl/sn_pkg.sv
package sn_pkg;
   // Encodings of the result element size code.
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } size_code_e;

   localparam int unsigned SIZE_CODE_W = 2;
endpackage

// File: rtl/sn_lane_clamp.sv
// Narrows one element of width 2*W to width W with saturation.
module sn_lane_clamp #(
   parameter int unsigned W = 8
) (
   input  logic [2*W-1:0] wide,
   input  logic           src_signed,
   input  logic           dst_signed,
   output logic [W-1:0]   narrow,
   output logic           clipped
);
   localparam int unsigned SW = 2 * W;
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] UMAX = {W{1'b1}};

   logic neg;
   logic hi_all_ones;
   logic hi_zero_s;
   logic hi_zero_u;

   always_comb begin
      neg         = wide[SW-1];
      hi_all_ones = &wide[SW-1:W-1];
      hi_zero_s   = ~|wide[SW-1:W-1];
      hi_zero_u   = ~|wide[SW-1:W];
      narrow      = wide[W-1:0];
      clipped     = 1'b0;
      unique case ({src_signed, dst_signed})
         2'b11: begin
            if (!(hi_all_ones || hi_zero_s)) begin
               narrow  = neg ? SMIN : SMAX;
               clipped = 1'b1;
            end
         end
         2'b10: begin
            if (neg) begin
               narrow  = '0;
               clipped = 1'b1;
            end else if (!hi_zero_u) begin
               narrow  = UMAX;
               clipped = 1'b1;
            end
         end
         2'b01: begin
            if (!hi_zero_s) begin
               narrow  = SMAX;
               clipped = 1'b1;
            end
         end
         default: begin
            if (!hi_zero_u) begin
               narrow  = UMAX;
               clipped = 1'b1;
            end
         end
      endcase
   end
endmodule

// File: rtl/sn_size_path.sv
// All lanes for one result width: packs HALF_W/DW narrowed lanes.
module sn_size_path #(
   parameter int unsigned HALF_W = 64,
   parameter int unsigned DW     = 8
) (
   input  logic [2*HALF_W-1:0] wide_src,
   input  logic                src_signed,
   input  logic                dst_signed,
   output logic [HALF_W-1:0]   packed_out,
   output logic [HALF_W-1:0]   lane0_out,
   output logic                clip_any,
   output logic                clip_lane0
);
   localparam int unsigned LANES = HALF_W / DW;

   if (LANES < 1 || (LANES * DW) != HALF_W) begin : g_bad_geom
      $error("sn_size_path: DW must divide HALF_W");
   end

   logic [LANES-1:0] clip;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      sn_lane_clamp #(.W(DW)) u_lane (
         .wide       (wide_src[l*2*DW +: 2*DW]),
         .src_signed (src_signed),
         .dst_signed (dst_signed),
         .narrow     (packed_out[l*DW +: DW]),
         .clipped    (clip[l])
      );
   end

   always_comb begin
      lane0_out          = '0;
      lane0_out[DW-1:0]  = packed_out[DW-1:0];
      clip_any           = |clip;
      clip_lane0         = clip[0];
   end
endmodule

// File: rtl/sn_merge.sv
// Places the narrowed half into the destination according to the form.
module sn_merge #(
   parameter int unsigned HALF_W = 64
) (
   input  logic [HALF_W-1:0]   half_vec,
   input  logic [HALF_W-1:0]   lane0_vec,
   input  logic                clip_any,
   input  logic                clip_lane0,
   input  logic                scalar_mode,
   input  logic                upper_half,
   input  logic [HALF_W-1:0]   cur_low,
   output logic [2*HALF_W-1:0] result,
   output logic                clipped
);
   always_comb begin
      if (scalar_mode) begin
         result  = {{HALF_W{1'b0}}, lane0_vec};
         clipped = clip_lane0;
      end else if (upper_half) begin
         result  = {half_vec, cur_low};
         clipped = clip_any;
      end else begin
         result  = {{HALF_W{1'b0}}, half_vec};
         clipped = clip_any;
      end
   end
endmodule

// File: rtl/sat_narrow_unit.sv
module sat_narrow_unit
   import sn_pkg::*;
#(
   parameter int unsigned BASE_W    = 8,
   parameter int unsigned NUM_SIZES = 3,
   parameter int unsigned HALF_W    = 64,
   parameter int unsigned STAT_W    = 32,
   parameter int unsigned SAT_BIT   = 27
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [2*HALF_W-1:0] src_vec,
   input  logic [2*HALF_W-1:0] dst_cur,
   input  logic [1:0]          size_code,
   input  logic                src_signed,
   input  logic                dst_signed,
   input  logic                scalar_mode,
   input  logic                upper_half,
   output logic [2*HALF_W-1:0] dst_out,
   output logic [STAT_W-1:0]   status_word,
   output logic                size_err
);
   localparam int unsigned VEC_W    = 2 * HALF_W;
   localparam int unsigned WIDEST_W = BASE_W << (NUM_SIZES - 1);

   if (NUM_SIZES < 1 || NUM_SIZES > (1 << SIZE_CODE_W)) begin : g_bad_sizes
      $error("sat_narrow_unit: NUM_SIZES out of range");
   end
   if ((HALF_W % WIDEST_W) != 0) begin : g_bad_half
      $error("sat_narrow_unit: HALF_W must be a multiple of the widest lane");
   end
   if (SAT_BIT >= STAT_W) begin : g_bad_stat
      $error("sat_narrow_unit: SAT_BIT outside the status word");
   end

   logic [HALF_W-1:0] path_vec [NUM_SIZES];
   logic [HALF_W-1:0] path_l0  [NUM_SIZES];
   logic [NUM_SIZES-1:0] path_clip_any;
   logic [NUM_SIZES-1:0] path_clip0;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      sn_size_path #(.HALF_W(HALF_W), .DW(BASE_W << s)) u_path (
         .wide_src   (src_vec),
         .src_signed (src_signed),
         .dst_signed (dst_signed),
         .packed_out (path_vec[s]),
         .lane0_out  (path_l0[s]),
         .clip_any   (path_clip_any[s]),
         .clip_lane0 (path_clip0[s])
      );
   end

   logic              size_ok;
   logic [HALF_W-1:0] sel_vec;
   logic [HALF_W-1:0] sel_l0;
   logic              sel_any;
   logic              sel_c0;

   always_comb begin
      size_ok = 1'b0;
      sel_vec = '0;
      sel_l0  = '0;
      sel_any = 1'b0;
      sel_c0  = 1'b0;
      for (int s = 0; s < NUM_SIZES; s++) begin
         if (size_code == SIZE_CODE_W'(s)) begin
            size_ok = 1'b1;
            sel_vec = path_vec[s];
            sel_l0  = path_l0[s];
            sel_any = path_clip_any[s];
            sel_c0  = path_clip0[s];
         end
      end
   end

   logic [VEC_W-1:0] next_dst;
   logic             next_clip;

   sn_merge #(.HALF_W(HALF_W)) u_merge (
      .half_vec    (sel_vec),
      .lane0_vec   (sel_l0),
      .clip_any    (sel_any),
      .clip_lane0  (sel_c0),
      .scalar_mode (scalar_mode),
      .upper_half  (upper_half),
      .cur_low     (dst_cur[HALF_W-1:0]),
      .result      (next_dst),
      .clipped     (next_clip)
   );

   logic [VEC_W-1:0] dst_q;
   logic             sat_q;
   logic             err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_q <= '0;
         sat_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         err_q <= op_valid && !size_ok;
         if (op_valid && size_ok) begin
            dst_q <= next_dst;
            if (next_clip) begin
               sat_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      status_word          = '0;
      status_word[SAT_BIT] = sat_q;
   end

   assign dst_out  = dst_q;
   assign size_err = err_q;
endmodule

// File: rtl/sn_narrow_chk.sv
module sn_narrow_chk #(
   parameter int unsigned HALF_W  = 64,
   parameter int unsigned STAT_W  = 32,
   parameter int unsigned SAT_BIT = 27
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic [2*HALF_W-1:0] dst_cur,
   input logic [1:0]          size_code,
   input logic                scalar_mode,
   input logic                upper_half,
   input logic [2*HALF_W-1:0] dst_out,
   input logic [STAT_W-1:0]   status_word,
   input logic                size_err
);
   localparam logic [STAT_W-1:0] OTHER_MASK = ~(STAT_W'(1) << SAT_BIT);

   logic legal_op;
   assign legal_op = op_valid && (size_code != 2'd3);

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(dst_out) && $stable(status_word)));

   p_bad_size_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && size_code == 2'd3) |=>
         (size_err && $stable(dst_out) && $stable(status_word)));

   p_err_only_bad_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && size_code == 2'd3) |=> !size_err);

   p_lower_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_op && !upper_half && !scalar_mode) |=>
         (dst_out[2*HALF_W-1:HALF_W] == '0));

   p_upper_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_op && upper_half && !scalar_mode) |=>
         (dst_out[HALF_W-1:0] == $past(dst_cur[HALF_W-1:0])));

   p_scalar_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (legal_op && scalar_mode && size_code == 2'd0) |=>
         (dst_out[2*HALF_W-1:8] == '0));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[SAT_BIT] |=> status_word[SAT_BIT]);

   p_other_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word & OTHER_MASK) == '0);
endmodule

bind sat_narrow_unit sn_narrow_chk #(
   .HALF_W  (HALF_W),
   .STAT_W  (STAT_W),
   .SAT_BIT (SAT_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .dst_cur     (dst_cur),
   .size_code   (size_code),
   .scalar_mode (scalar_mode),
   .upper_half  (upper_half),
   .dst_out     (dst_out),
   .status_word (status_word),
   .size_err    (size_err)
);

// File: tb/sat_narrow_unit_bench.sv
module sat_narrow_unit_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [127:0] src_vec = '0;
   logic [127:0] dst_cur = '0;
   logic [1:0]   size_code = '0;
   logic         src_signed = 1'b0;
   logic         dst_signed = 1'b0;
   logic         scalar_mode = 1'b0;
   logic         upper_half = 1'b0;
   logic [127:0] dst_out;
   logic [31:0]  status_word;
   logic         size_err;

   always #4 clk = ~clk;

   sat_narrow_unit u_sat_narrow_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_valid    (op_valid),
      .src_vec     (src_vec),
      .dst_cur     (dst_cur),
      .size_code   (size_code),
      .src_signed  (src_signed),
      .dst_signed  (dst_signed),
      .scalar_mode (scalar_mode),
      .upper_half  (upper_half),
      .dst_out     (dst_out),
      .status_word (status_word),
      .size_err    (size_err)
   );

   typedef struct packed {
      logic [1:0]   sz;
      logic         ss;
      logic         ds;
      logic         sc;
      logic         up;
      logic [127:0] src;
      logic [127:0] cur;
      logic [127:0] exp;
      logic         sat;
      logic [23:0]  req;
   } row_t;

   localparam logic [127:0] CUR_A = 128'hAAAAAAAAAAAAAAAAAAAAAAAAAAAAAAAA;
   localparam logic [127:0] CUR_F = 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF;
   localparam int NROWS = 12;
   localparam row_t ROWS [NROWS] = '{
      // R6: in-range values incl. a negative one pass through
      '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 128'hFFF90007000600050004000300020001, CUR_A,
        128'h0000000000000000F907060504030201, 1'b0, "R6"},
      // R2: signed->signed, 8-bit lanes, both bounds
      '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 128'hFFFF0000007FFF8080007FFFFF7F0080, CUR_A,
        128'h0000000000000000FF007F80807F807F, 1'b1, "R2"},
      // R3: signed->unsigned, negative to 0, large to max
      '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 128'h00001234FFFFFFFF000100000000FFFF, CUR_A,
        128'h000000000000000012340000FFFFFFFF, 1'b1, "R3"},
      // R4: unsigned->signed, upper clamp only
      '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 128'h00000005FFFFFFFF0000800000007FFF, CUR_A,
        128'h000000000000000000057FFF7FFF7FFF, 1'b1, "R4"},
      // R5: unsigned->unsigned, 32-bit lanes
      '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 128'h000000010000000000000000FFFFFFFF, CUR_A,
        128'h0000000000000000FFFFFFFFFFFFFFFF, 1'b1, "R5"},
      // R8: upper-half form keeps low half of dst_cur
      '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 128'h000000007FFFFFFFFFFFFFFF80000000,
        128'h11111111111111112222222233333333,
        128'h7FFFFFFF800000002222222233333333, 1'b0, "R8"},
      // R2: signed->signed, 32-bit lanes
      '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 128'hFFFFFFFF7FFFFFFF0000000080000000, CUR_A,
        128'h0000000000000000800000007FFFFFFF, 1'b1, "R2"},
      // R9: scalar ignores upper_half and the other lanes' clamps
      '{2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFF0042,
        128'h55555555555555555555555555555555,
        128'h00000000000000000000000000000042, 1'b0, "R9"},
      // R9: scalar lane 0 clamp
      '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 128'h00000000000000000000000000010000, CUR_A,
        128'h00000000000000000000000000007FFF, 1'b1, "R9"},
      // R8: upper-half form, unsigned->unsigned, 8-bit lanes
      '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 128'h010001000100010001000100010000AB,
        128'hDEADBEEFDEADBEEF0123456789ABCDEF,
        128'hFFFFFFFFFFFFFFAB0123456789ABCDEF, 1'b1, "R8"},
      // R1: 8 byte lanes, lane order
      '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 128'h00110022003300440055006600770088, CUR_F,
        128'h00000000000000001122334455667788, 1'b0, "R1"},
      // R7: lower form clears top half
      '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 128'h00000001000000020000000300000004, CUR_F,
        128'h00000000000000000001000200030004, 1'b0, "R7"}
   };

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] sz, input logic ss, input logic ds,
                        input logic sc, input logic up,
                        input logic [127:0] src, input logic [127:0] cur);
      @(negedge clk);
      size_code   = sz;
      src_signed  = ss;
      dst_signed  = ds;
      scalar_mode = sc;
      upper_half  = up;
      src_vec     = src;
      dst_cur     = cur;
      op_valid    = 1'b1;
      @(negedge clk);
      op_valid    = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic         sticky;
      logic [127:0] last_dst;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      check("R12", "reset dst_out", dst_out, '0);
      check("R12", "reset status", 128'(status_word), '0);
      check("R12", "reset size_err", 128'(size_err), '0);

      sticky = 1'b0;
      for (int i = 0; i < NROWS; i++) begin
         apply(ROWS[i].sz, ROWS[i].ss, ROWS[i].ds, ROWS[i].sc, ROWS[i].up,
               ROWS[i].src, ROWS[i].cur);
         sticky = sticky | ROWS[i].sat;
         check($sformatf("%s", ROWS[i].req), $sformatf("row %0d dst_out", i),
               dst_out, ROWS[i].exp);
         // R10: sticky flag at bit 27
         check("R10", $sformatf("row %0d status", i),
               128'(status_word), 128'(32'(sticky) << 27));
         check("R11", $sformatf("row %0d size_err", i), 128'(size_err), '0);
      end
      last_dst = ROWS[NROWS-1].exp;

      // R11: illegal size leaves state alone and flags an error
      apply(2'd3, 1'b1, 1'b1, 1'b0, 1'b0, CUR_F, CUR_A);
      check("R11", "illegal dst_out", dst_out, last_dst);
      check("R11", "illegal status", 128'(status_word), 128'(32'h0800_0000));
      check("R11", "illegal size_err", 128'(size_err), 128'(1'b1));
      @(negedge clk);
      check("R11", "size_err pulse end", 128'(size_err), '0);

      // R12: idle cycles with changing inputs hold the result
      src_vec = CUR_F;
      size_code = 2'd0;
      repeat (3) @(negedge clk);
      check("R12", "idle hold dst_out", dst_out, last_dst);

      // R10: reset clears flag; a clean op keeps it clear
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R10", "status after reset", 128'(status_word), '0);
      apply(ROWS[0].sz, ROWS[0].ss, ROWS[0].ds, ROWS[0].sc, ROWS[0].up,
            ROWS[0].src, ROWS[0].cur);
      check("R10", "no clamp keeps flag clear", 128'(status_word), '0);

      // R3 + R9: scalar 32-bit, negative signed source to unsigned -> 0
      apply(2'd2, 1'b1, 1'b0, 1'b1, 1'b0,
            128'h0000000000000000FFFFFFFFFFFFFFFF, CUR_A);
      check("R3", "scalar negative to zero", dst_out, '0);
      check("R10", "scalar clamp sets flag", 128'(status_word),
            128'(32'h0800_0000));

      finish_run();
   end
endmodule